// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind the serial command sequencer of a small non-volatile byte array. Once the sequencer has decoded a write command and its address, it signals the start together with a 9-bit start address. The high address bit comes from the command byte and the low eight bits from the address byte that follows it. Data bytes then stream in over a valid/ready interface and are kept in a 16-entry page buffer. A per-position valid mask records which entries have been filled.

When the chip select rises, the engine decides whether to commit the buffered page. A commit starts a timed write cycle with the busy flag (WIP) held high. During the first sixteen cycles of that window, the filled buffer entries are copied into the array through a simple write port, one position per cycle. When the window ends, a one-cycle pulse tells the status logic to clear its write-enable latch.

The stream rule is plain: a byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while a write is collecting data and no chip-select rise is presented in that cycle. A byte offered while `in_ready` is low is not taken and has no effect. The sender must hold it or drop it.

Top module: `pgw_engine`

## Requirements
- R1: During and right after reset, `wip`, `wel_clr`, `mem_we` and `in_ready` are all low.
- R2: `wr_start` seen while `wip` is low begins a new collection and clears the byte mask. The k-th accepted byte (k from 0) lands at array address `{wr_addr[8:4], (wr_addr[3:0]+k) mod 16}`. Only the low four address bits advance.
- R3: When more than 16 bytes are sent, the offset wraps inside the same page. A later byte overwrites the earlier one at that offset, and each offset is written to the array at most once per commit.
- R4: `in_ready` is high only while collecting and while `cs_rise` is low. A byte is taken only when `in_valid` and `in_ready` are both high.
- R5: A commit happens only on a `cs_rise` pulse while collecting, with `byte_aligned` high and at least one byte accepted. Any other chip-select rise ends the collection with no array write and no `wip`.
- R6: No commit happens while `wel` is low or `wp_n` is low at the `cs_rise` cycle.
- R7: After a commit, `wip` rises in the cycle after `cs_rise` and stays high for exactly max(`cyc_len`, 16) cycles.
- R8: During the first 16 cycles of `wip`, the cycle with index j (j from 0) writes page offset j, but only if that offset was filled. All writes go to the one page chosen at start.
- R9: Protection uses `bp` and address bits [8:7]. 00 protects nothing, 01 protects the top quarter (bits = 11), 10 protects the top half (bit 8 = 1), and 11 protects the whole array. A protected commit makes no array write but still runs the full `wip` window.
- R10: `wel_clr` is a one-cycle pulse in the last cycle of every `wip` window, including protected ones.
- R11: While `wip` is high, `wr_start`, `in_valid` and `cs_rise` have no effect. After the window the engine is idle, and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_len | input | 12 | Programmed write-cycle length in clocks (minimum 16 applied) |
| wr_start | input | 1 | Pulse: write command and address decoded |
| wr_addr | input | 9 | Start address of the write |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Engine can take a data byte |
| in_data | input | 8 | Data byte |
| byte_aligned | input | 1 | Serial bit counter is at a byte boundary |
| cs_rise | input | 1 | Pulse: chip select rose |
| wel | input | 1 | Write-enable latch level |
| wp_n | input | 1 | Write-protect pin level, high allows writes |
| bp | input | 2 | Block-protect level |
| wip | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the engine with its default parameters: 9 address bits, 8-bit data, 16-byte pages and a 12-bit cycle counter. At that size the whole 512-byte array can be mirrored and compared after every transaction. The sweep covers every start offset within a page against byte counts below, at and beyond the page size. The cycle length is set below, at and above the 16-cycle floor, and every protection level is tried against every quarter of the array.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [0:0] {
    PGW_IDLE = 1'b0,
    PGW_FILL = 1'b1
  } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [OFF_W-1:0]      widx,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [OFF_W-1:0]      ridx,
  output logic [DATA_W-1:0]     rdata,
  output logic [PAGE_BYTES-1:0] mask
);
  logic [PAGE_BYTES*DATA_W-1:0] flat;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr) begin
        vld_q  <= 1'b0;
      end else if (we && (widx == OFF_W'(g))) begin
        slot_q <= wdata;
        vld_q  <= 1'b1;
      end
    end
    assign flat[g*DATA_W +: DATA_W] = slot_q;
    assign mask[g]                  = vld_q;
  end

  assign rdata = flat[ridx*DATA_W +: DATA_W];

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0)) else $error("mask survived clear"); // R2
endmodule

// File: rtl/pgw_region_guard.sv
module pgw_region_guard #(
  parameter int PAGE_W = 5
) (
  input  logic [1:0]        bp,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  logic [1:0] quarter;
  assign quarter = page[PAGE_W-1 -: 2];

  always_comb begin
    unique case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (quarter == 2'b11);
      2'b10:   hit = quarter[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
  parameter int CYC_W   = 12,
  parameter int MIN_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CYC_W-1:0] len,
  output logic             active,
  output logic             last
);
  localparam logic [CYC_W-1:0] FLOOR = CYC_W'(MIN_LEN);

  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] eff_len;

  assign eff_len = (len < FLOOR) ? FLOOR : len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= eff_len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == CYC_W'(1));

  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> !active) else $error("window overran"); // R7
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine import pgw_pkg::*; #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int CYC_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  cyc_len,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              byte_aligned,
  input  logic              cs_rise,
  input  logic              wel,
  input  logic              wp_n,
  input  logic [1:0]        bp,
  output logic              wip,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W:0] STEP_DONE = (OFF_W+1)'(PAGE_BYTES);

  pgw_state_e        state_q;
  logic [PAGE_W-1:0] base_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              prot_q;
  logic [OFF_W:0]    step_q;

  logic                  accept_start;
  logic                  take;
  logic                  commit;
  logic                  region_hit;
  logic [DATA_W-1:0]     buf_rdata;
  logic [PAGE_BYTES-1:0] buf_mask;

  assign accept_start = wr_start && !wip;
  assign in_ready     = (state_q == PGW_FILL) && !cs_rise;
  assign take         = in_valid && in_ready;
  assign commit       = (state_q == PGW_FILL) && cs_rise && byte_aligned
                        && (|buf_mask) && wel && wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PGW_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
    end else if (accept_start) begin
      state_q <= PGW_FILL;
      base_q  <= wr_addr[ADDR_W-1:OFF_W];
      ptr_q   <= wr_addr[OFF_W-1:0];
    end else begin
      if (state_q == PGW_FILL && cs_rise) state_q <= PGW_IDLE;
      if (take)                           ptr_q   <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      step_q <= STEP_DONE;
    end else if (commit) begin
      prot_q <= region_hit;
      step_q <= '0;
    end else if (!step_q[OFF_W]) begin
      step_q <= step_q + 1'b1;
    end
  end

  pgw_page_buf #(
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_start),
    .we    (take),
    .widx  (ptr_q),
    .wdata (in_data),
    .ridx  (step_q[OFF_W-1:0]),
    .rdata (buf_rdata),
    .mask  (buf_mask)
  );

  pgw_region_guard #(
    .PAGE_W (PAGE_W)
  ) u_guard (
    .bp   (bp),
    .page (base_q),
    .hit  (region_hit)
  );

  pgw_cycle_timer #(
    .CYC_W   (CYC_W),
    .MIN_LEN (PAGE_BYTES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (commit),
    .len    (cyc_len),
    .active (wip),
    .last   (wel_clr)
  );

  assign mem_we    = wip && !step_q[OFF_W] && buf_mask[step_q[OFF_W-1:0]] && !prot_q;
  assign mem_addr  = {base_q, step_q[OFF_W-1:0]};
  assign mem_wdata = buf_rdata;

  AST_WE_INSIDE_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip) else $error("array write outside window"); // R8
  AST_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])))
    else $error("page changed mid commit"); // R8
  AST_WIP_FROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise && byte_aligned)) else $error("window without aligned cs rise"); // R5
  AST_WIP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel && wp_n)) else $error("window without enable"); // R6
  AST_WELCLR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wip) else $error("wel_clr not in last cycle"); // R10
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !wip) else $error("ready during window"); // R11
endmodule

// File: tb/test_pgw_engine.sv
module test_pgw_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int CYC_W  = 12;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk, rst_n;
  logic [CYC_W-1:0]  cyc_len;
  logic              wr_start, in_valid, in_ready, byte_aligned, cs_rise, wel, wp_n;
  logic [ADDR_W-1:0] wr_addr, mem_addr;
  logic [DATA_W-1:0] in_data, mem_wdata;
  logic [1:0]        bp;
  logic              wip, wel_clr, mem_we;

  pgw_engine i_pgw_engine (
    .clk(clk), .rst_n(rst_n), .cyc_len(cyc_len), .wr_start(wr_start), .wr_addr(wr_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .byte_aligned(byte_aligned),
    .cs_rise(cs_rise), .wel(wel), .wp_n(wp_n), .bp(bp), .wip(wip), .wel_clr(wel_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0;
  int fails  = 0;
  int wip_cycles, welclr_seen, dup_writes;
  logic [DATA_W-1:0] dut_mem [DEPTH];
  logic [DATA_W-1:0] exp_mem [DEPTH];
  bit   written [DEPTH];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_we) begin
      if (written[mem_addr]) dup_writes++;
      written[mem_addr] = 1'b1;
      dut_mem[mem_addr] = mem_wdata;
    end
    if (wip)     wip_cycles++;
    if (wel_clr) welclr_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit prot_f(input logic [1:0] b, input int addr);
    int q = (addr >> 7) & 3;
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return q == 3;
      2'b10:   return q >= 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_txn(input int start, input int n, input bit aligned, input bit wel_v,
                         input bit wpn_v, input logic [1:0] bp_v, input int len,
                         input int seed, input string req);
    bit commit;
    int exp_len, mism;
    @(negedge clk);
    wr_start = 1'b1; wr_addr = ADDR_W'(start);
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = DATA_W'(seed + i * 29);
      #1 chk(in_ready == 1'b1, "R4 ready while collecting", int'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    cs_rise = 1'b1; byte_aligned = aligned; wel = wel_v; wp_n = wpn_v; bp = bp_v;
    cyc_len = CYC_W'(len);
    wip_cycles = 0; welclr_seen = 0; dup_writes = 0;
    for (int a = 0; a < DEPTH; a++) written[a] = 1'b0;
    #1 chk(in_ready == 1'b0, "R4 ready low with cs_rise", int'(in_ready), 0);
    @(negedge clk);
    cs_rise = 1'b0;
    for (int k = 0; k < 5000 && wip; k++) @(negedge clk);
    @(negedge clk); #1;
    commit  = aligned && (n > 0) && wel_v && wpn_v;
    exp_len = commit ? ((len < 16) ? 16 : len) : 0;
    chk(wip_cycles == exp_len, {req, " R7 wip length"}, wip_cycles, exp_len);
    chk(welclr_seen == int'(commit), {req, " R10 wel_clr pulses"}, welclr_seen, int'(commit));
    chk(dup_writes == 0, {req, " R3 one write per offset"}, dup_writes, 0);
    if (commit && !prot_f(bp_v, start)) begin
      for (int i = 0; i < n; i++)
        exp_mem[(start & ~15) | ((start + i) & 15)] = DATA_W'(seed + i * 29);
    end
    mism = 0;
    for (int a = 0; a < DEPTH; a++) if (dut_mem[a] !== exp_mem[a]) mism++;
    chk(mism == 0, {req, " array contents"}, mism, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ns [7] = '{1, 2, 5, 15, 16, 17, 20};
    for (int a = 0; a < DEPTH; a++) begin dut_mem[a] = '0; exp_mem[a] = '0; end
    rst_n = 1'b0; cyc_len = '0; wr_start = 1'b0; wr_addr = '0; in_valid = 1'b0;
    in_data = '0; byte_aligned = 1'b0; cs_rise = 1'b0; wel = 1'b0; wp_n = 1'b0; bp = 2'b00;
    repeat (3) @(negedge clk);
    chk({wip, wel_clr, mem_we, in_ready} == 4'b0, "R1 outputs in reset",
        int'({wip, wel_clr, mem_we, in_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({wip, wel_clr, mem_we, in_ready} == 4'b0, "R1 outputs after reset",
        int'({wip, wel_clr, mem_we, in_ready}), 0);

    // R2 R3 R7 R8: every page offset against byte counts around the page size
    for (int off = 0; off < 16; off++)
      for (int k = 0; k < 7; k++)
        run_txn(off + 16 * ((off * 5 + k * 3) % 32), ns[k], 1'b1, 1'b1, 1'b1, 2'b00,
                (k % 3 == 0) ? 0 : ((k % 3 == 1) ? 16 : 23), off * 7 + k + 1, "R2 R8 sweep");

    // R9: each protect level against each quarter
    for (int b = 0; b < 4; b++)
      for (int q = 0; q < 4; q++)
        run_txn(q * 128 + 16 * b + 3, 4, 1'b1, 1'b1, 1'b1, 2'(b), 18, 100 + b * 4 + q, "R9 protect");

    // R5 / R6: rejected commits
    run_txn(40, 3, 1'b0, 1'b1, 1'b1, 2'b00, 16, 201, "R5 misaligned cs");
    run_txn(40, 0, 1'b1, 1'b1, 1'b1, 2'b00, 16, 202, "R5 no data byte");
    run_txn(72, 3, 1'b1, 1'b0, 1'b1, 2'b00, 16, 203, "R6 wel low");
    run_txn(72, 3, 1'b1, 1'b1, 1'b0, 2'b00, 16, 204, "R6 wp_n low");

    // R11: requests during the write window are ignored
    @(negedge clk);
    wr_start = 1'b1; wr_addr = 9'd300;
    @(negedge clk);
    wr_start = 1'b0; in_valid = 1'b1; in_data = 8'hA5;
    @(negedge clk);
    in_valid = 1'b0; cs_rise = 1'b1; byte_aligned = 1'b1; wel = 1'b1; wp_n = 1'b1;
    bp = 2'b00; cyc_len = 12'd40;
    @(negedge clk);
    cs_rise = 1'b0;
    exp_mem[300] = 8'hA5;
    repeat (5) @(negedge clk);
    wr_start = 1'b1; wr_addr = 9'd20; in_valid = 1'b1; in_data = 8'h3C;
    #1 chk(in_ready == 1'b0, "R11 ready low in window", int'(in_ready), 0);
    @(negedge clk);
    wr_start = 1'b0; in_valid = 1'b0;
    for (int k = 0; k < 100 && wip; k++) @(negedge clk);
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R11 no collection after window", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'h3C; cs_rise = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; cs_rise = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk(wip == 1'b0, "R11 idle cs_rise no window", int'(wip), 0);
    begin
      int mism = 0;
      for (int a = 0; a < DEPTH; a++) if (dut_mem[a] !== exp_mem[a]) mism++;
      chk(mism == 0, "R11 array contents", mism, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule